// File: doc/BRIEF.md
# Serial transmit handshake sequencer

This block runs the transmit half of an asynchronous serial controller. It holds one buffered character and one character being shifted out. It drives a request-to-send line and a break line, and it watches a clear-to-send input. It decides when the buffered character moves into the shifter, when the line is forced into break, and when request-to-send may fall. Parity, baud-rate generation and reception are handled elsewhere. The bit rate comes from an external strobe, one pulse per bit time.

Software-side logic loads a character with a one-cycle write strobe. It sets or clears the two control bits (keep request-to-send raised, request break) with their own write strobes, and it picks a character length code. Transmission needs request-to-send raised, clear-to-send active and no break in progress. Request-to-send is only released once both storage stages have drained. A break request is honoured only while the transmitter is idle.

Top module: `txh_top`

## Requirements
- R1: After reset, rts and brk are 0, buf_empty and shift_empty are 1, and txd is 1.
- R2: A buf_wr pulse stores buf_data and clears buf_empty. If in that cycle the shifter is empty, rts is 1, cts is 1 and brk is 0, the character moves into the shifter at once: shift_empty goes to 0 and buf_empty returns to 1.
- R3: Each frame is one low start bit, then the data bits least significant first, then one high stop bit. Each bit advances on a tick pulse. The number of data bits is 5 + len_code (0→5, 1→6, 2→7, 3→8), sampled when the character enters the shifter.
- R4: When the last stop bit ends, the block picks the first true case in this order. (a) If the buffer is full and cts=1, the next character starts. (b) Otherwise, if the break request bit is set and cts=1, brk rises. (c) Otherwise, if the keep-rts bit is clear and either cts=0 or (the buffer is empty and brk=0), rts falls.
- R5: Setting the keep-rts bit makes rts 1 on the next clock edge. If cts=1 at that time, a pending character starts when the shifter is empty and brk=0. Otherwise, if the break request bit is set and both stages are empty, brk rises.
- R6: Clearing the keep-rts bit lowers rts only when both stages are empty and brk=0. In any other state rts stays 1.
- R7: Setting the break request bit raises brk only when both stages are empty and rts and cts are both 1.
- R8: Clearing the break request bit while brk=1 lowers brk. If the buffer is then full and cts=1, that character starts. Otherwise, if the keep-rts bit is clear, rts falls.
- R9: When cts rises while rts=1 and the shifter is empty, a pending character starts if brk=0. Otherwise, if the break request bit is set and the buffer is empty, brk rises. A falling cts does not stop a frame already in progress.
- R10: txd is 0 whenever brk=1. txd is 1 whenever brk=0 and the shifter is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe per bit time |
| buf_wr | input | 1 | Load strobe for the transmit buffer |
| buf_data | input | 8 | Character to load |
| rtson_wr | input | 1 | Write strobe for the keep-rts bit |
| rtson_val | input | 1 | New value of the keep-rts bit |
| brkon_wr | input | 1 | Write strobe for the break request bit |
| brkon_val | input | 1 | New value of the break request bit |
| len_code | input | 2 | Character length code, 5 + value data bits |
| cts | input | 1 | Clear-to-send, 1 = active |
| txd | output | 1 | Serial line |
| rts | output | 1 | Request-to-send, 1 = active |
| brk | output | 1 | Break in progress |
| buf_empty | output | 1 | Transmit buffer empty |
| shift_empty | output | 1 | Shift stage empty |

## Verification
The bench targets several corner cases. One is a second character written while the first is still shifting, followed by a cts drop. A design that ignored cts at the end of a frame would send the held character anyway, and one that treated a busy shifter as idle would let rts fall while the buffer is still full. Another is clearing the keep-rts bit or requesting break while a character waits. A faulty design would drop rts or start a break mid-stream, and the final flag and line checks catch both. The last is a cts rise that releases a held character, and a break release with and without a waiting character. Here a wrong priority order shows up as a missing frame, an extra frame or a stuck brk.

// File: rtl/txh_pkg.sv
package txh_pkg;
    localparam int CHAR_W = 8;
    localparam int CNT_W  = $clog2(CHAR_W);
    localparam int MIN_BITS = 5;

    typedef enum logic [1:0] {
        SER_IDLE  = 2'd0,
        SER_START = 2'd1,
        SER_DATA  = 2'd2,
        SER_STOP  = 2'd3
    } ser_state_e;

    typedef struct packed {
        logic [CHAR_W-1:0] hold;
        logic              buf_empty;
        logic              sh_empty;
        logic              keep_rts;
        logic              brk_req;
        logic              rts;
        logic              brk;
        logic              cts_prev;
    } ctrl_s;

    typedef struct packed {
        ser_state_e        state;
        logic [CHAR_W-1:0] sreg;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  last;
    } ser_s;
endpackage

// File: rtl/txh_ser.sv
module txh_ser
    import txh_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start_i,
    input  logic [CHAR_W-1:0] data_i,
    input  logic [1:0]        len_i,
    output logic              line_o,
    output logic              done_o
);
    localparam ser_s SER_RST = '{state: SER_IDLE, sreg: '0, cnt: '0, last: '0};

    ser_s ser_d, ser_q;

    always_comb begin
        ser_d  = ser_q;
        done_o = 1'b0;
        unique case (ser_q.state)
            SER_START: if (tick) begin
                ser_d.state = SER_DATA;
                ser_d.cnt   = '0;
            end
            SER_DATA: if (tick) begin
                ser_d.sreg = ser_q.sreg >> 1;
                if (ser_q.cnt == ser_q.last) ser_d.state = SER_STOP;
                else ser_d.cnt = ser_q.cnt + 1'b1;
            end
            SER_STOP: if (tick) begin
                done_o      = 1'b1;
                ser_d.state = SER_IDLE;
            end
            default: ;
        endcase
        if (start_i) begin
            ser_d.state = SER_START;
            ser_d.sreg  = data_i;
            ser_d.last  = CNT_W'(MIN_BITS - 1) + CNT_W'(len_i);
        end
    end

    always_comb begin
        unique case (ser_q.state)
            SER_START: line_o = 1'b0;
            SER_DATA:  line_o = ser_q.sreg[0];
            default:   line_o = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ser_q <= SER_RST;
        else        ser_q <= ser_d;
    end

    // R3
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> (ser_q.state == SER_IDLE || done_o));
endmodule

// File: rtl/txh_ctrl.sv
module txh_ctrl
    import txh_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buf_wr_i,
    input  logic [CHAR_W-1:0] buf_data_i,
    input  logic              rtson_wr_i,
    input  logic              rtson_val_i,
    input  logic              brkon_wr_i,
    input  logic              brkon_val_i,
    input  logic              cts_i,
    input  logic              done_i,
    output logic              start_o,
    output logic [CHAR_W-1:0] start_data_o,
    output logic              rts_o,
    output logic              brk_o,
    output logic              buf_empty_o,
    output logic              sh_empty_o
);
    localparam ctrl_s CTRL_RST = '{hold: '0, buf_empty: 1'b1, sh_empty: 1'b1,
                                   keep_rts: 1'b0, brk_req: 1'b0, rts: 1'b0,
                                   brk: 1'b0, cts_prev: 1'b0};

    ctrl_s ctl_d, ctl_q;

    function automatic ctrl_s launch(input ctrl_s s);
        ctrl_s r = s;
        r.sh_empty  = 1'b0;
        r.buf_empty = 1'b1;
        return r;
    endfunction

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.cts_prev = cts_i;
        start_o      = 1'b0;
        start_data_o = ctl_q.hold;

        // end of a frame
        if (done_i) begin
            ctl_d.sh_empty = 1'b1;
            if (!ctl_d.buf_empty && cts_i) begin
                start_data_o = ctl_d.hold; ctl_d = launch(ctl_d); start_o = 1'b1;
            end else if (ctl_d.brk_req && cts_i) begin
                ctl_d.brk = 1'b1;
            end else if (!ctl_d.keep_rts && (!cts_i || (ctl_d.buf_empty && !ctl_d.brk))) begin
                ctl_d.rts = 1'b0;
            end
        end

        // buffer load
        if (buf_wr_i) begin
            ctl_d.hold      = buf_data_i;
            ctl_d.buf_empty = 1'b0;
            if (ctl_d.sh_empty && ctl_d.rts && cts_i && !ctl_d.brk) begin
                start_data_o = ctl_d.hold; ctl_d = launch(ctl_d); start_o = 1'b1;
            end
        end

        // keep-rts bit
        if (rtson_wr_i) begin
            ctl_d.keep_rts = rtson_val_i;
            if (rtson_val_i || (ctl_d.buf_empty && ctl_d.sh_empty && !ctl_d.brk)) begin
                ctl_d.rts = rtson_val_i;
                if (rtson_val_i && cts_i) begin
                    if (ctl_d.sh_empty && !ctl_d.buf_empty && !ctl_d.brk) begin
                        start_data_o = ctl_d.hold; ctl_d = launch(ctl_d); start_o = 1'b1;
                    end else if (ctl_d.brk_req && ctl_d.sh_empty && ctl_d.buf_empty) begin
                        ctl_d.brk = 1'b1;
                    end
                end
            end
        end

        // break request bit
        if (brkon_wr_i) begin
            ctl_d.brk_req = brkon_val_i;
            if (ctl_d.brk && !brkon_val_i) begin
                ctl_d.brk = 1'b0;
                if (!ctl_d.buf_empty && ctl_d.sh_empty && cts_i) begin
                    start_data_o = ctl_d.hold; ctl_d = launch(ctl_d); start_o = 1'b1;
                end else if (!ctl_d.keep_rts) begin
                    ctl_d.rts = 1'b0;
                end
            end else if (ctl_d.buf_empty && ctl_d.sh_empty && ctl_d.rts && cts_i) begin
                ctl_d.brk = brkon_val_i;
            end
        end

        // clear-to-send becoming active
        if (cts_i && !ctl_q.cts_prev && ctl_d.rts && ctl_d.sh_empty) begin
            if (!ctl_d.buf_empty && !ctl_d.brk) begin
                start_data_o = ctl_d.hold; ctl_d = launch(ctl_d); start_o = 1'b1;
            end else if (ctl_d.brk_req && ctl_d.buf_empty) begin
                ctl_d.brk = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= CTRL_RST;
        else        ctl_q <= ctl_d;
    end

    assign rts_o       = ctl_q.rts;
    assign brk_o       = ctl_q.brk;
    assign buf_empty_o = ctl_q.buf_empty;
    assign sh_empty_o  = ctl_q.sh_empty;

    // R5
    rts_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rtson_wr_i && rtson_val_i) |=> ctl_q.rts);
    // R6
    rts_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_q.rts) |-> !ctl_q.keep_rts);
    // R7
    brk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q.brk) |-> (ctl_q.buf_empty && ctl_q.sh_empty));
    // R4
    chain_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !ctl_q.buf_empty && cts_i) |=> !ctl_q.sh_empty);
    // R2
    load_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_i |=> !(ctl_q.buf_empty && ctl_q.sh_empty));
endmodule

// File: rtl/txh_top.sv
module txh_top
    import txh_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              buf_wr,
    input  logic [CHAR_W-1:0] buf_data,
    input  logic              rtson_wr,
    input  logic              rtson_val,
    input  logic              brkon_wr,
    input  logic              brkon_val,
    input  logic [1:0]        len_code,
    input  logic              cts,
    output logic              txd,
    output logic              rts,
    output logic              brk,
    output logic              buf_empty,
    output logic              shift_empty
);
    logic              start;
    logic              done;
    logic              ser_line;
    logic [CHAR_W-1:0] start_data;

    txh_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .buf_wr_i    (buf_wr),
        .buf_data_i  (buf_data),
        .rtson_wr_i  (rtson_wr),
        .rtson_val_i (rtson_val),
        .brkon_wr_i  (brkon_wr),
        .brkon_val_i (brkon_val),
        .cts_i       (cts),
        .done_i      (done),
        .start_o     (start),
        .start_data_o(start_data),
        .rts_o       (rts),
        .brk_o       (brk),
        .buf_empty_o (buf_empty),
        .sh_empty_o  (shift_empty)
    );

    txh_ser u_ser (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .start_i(start),
        .data_i (start_data),
        .len_i  (len_code),
        .line_o (ser_line),
        .done_o (done)
    );

    assign txd = brk ? 1'b0 : ser_line;

    // R10
    idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!brk && shift_empty) |-> txd);
endmodule

// File: tb/txh_top_tb_top.sv
module txh_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       buf_wr = 1'b0;
    logic [7:0] buf_data = 8'h00;
    logic       rtson_wr = 1'b0, rtson_val = 1'b0;
    logic       brkon_wr = 1'b0, brkon_val = 1'b0;
    logic [1:0] len_code = 2'd3;
    logic       cts = 1'b0;
    logic       txd, rts, brk, buf_empty, shift_empty;

    int n_chk = 0;
    int n_bad = 0;

    txh_top dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .buf_wr(buf_wr), .buf_data(buf_data),
        .rtson_wr(rtson_wr), .rtson_val(rtson_val), .brkon_wr(brkon_wr),
        .brkon_val(brkon_val), .len_code(len_code), .cts(cts), .txd(txd), .rts(rts),
        .brk(brk), .buf_empty(buf_empty), .shift_empty(shift_empty)
    );

    always #5 clk = ~clk;

    int tcnt = 0;
    initial forever begin
        @(posedge clk); #1;
        tcnt = (tcnt + 1) % 4;
        tick = (tcnt == 0);
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference model
    bit m_be = 1, m_busy = 0, m_rts = 0, m_brk = 0, m_keep = 0, m_breq = 0, m_cts = 0;
    int m_hold = 0, m_len = 3;
    int exp_data[4096];
    int exp_len[4096];
    int wr_p = 0, rd_p = 0;

    function automatic void m_start();
        int nb = m_len + 5;
        exp_data[wr_p % 4096] = m_hold & ((1 << nb) - 1);
        exp_len[wr_p % 4096]  = nb;
        wr_p++;
        m_busy = 1; m_be = 1;
    endfunction

    function automatic void m_write(input int d);
        m_hold = d; m_be = 0;
        if (!m_busy && m_rts && m_cts && !m_brk) m_start();
    endfunction

    function automatic void m_rtson(input bit v);
        m_keep = v;
        if (v || (m_be && !m_busy && !m_brk)) begin
            m_rts = v;
            if (v && m_cts) begin
                if (!m_busy && !m_be && !m_brk) m_start();
                else if (m_breq && !m_busy && m_be) m_brk = 1;
            end
        end
    endfunction

    function automatic void m_brkon(input bit v);
        m_breq = v;
        if (m_brk && !v) begin
            m_brk = 0;
            if (!m_be && !m_busy && m_cts) m_start();
            else if (!m_keep) m_rts = 0;
        end else if (m_be && !m_busy && m_rts && m_cts) m_brk = v;
    endfunction

    function automatic void m_setcts(input bit v);
        if (v && !m_cts) begin
            m_cts = 1;
            if (m_rts && !m_busy) begin
                if (!m_be && !m_brk) m_start();
                else if (m_breq && m_be) m_brk = 1;
            end
        end else m_cts = v;
    endfunction

    function automatic void m_complete();
        m_busy = 0;
        if (!m_be && m_cts) m_start();
        else if (m_breq && m_cts) m_brk = 1;
        else if (!m_keep && (!m_cts || (m_be && !m_brk))) m_rts = 0;
    endfunction

    // frame decoder on the serial line (R3)
    bit in_frame = 0;
    int bi = 0, nb_cur = 0, shv = 0;
    always @(negedge clk) begin
        if (rst_n && tick) begin
            if (!in_frame) begin
                if (!brk && !txd) begin
                    in_frame = 1; bi = 0; shv = 0;
                    if (rd_p < wr_p) nb_cur = exp_len[rd_p % 4096];
                    else begin nb_cur = 8; chk("R3 unexpected frame", 1, 0); end
                end
            end else if (bi < nb_cur) begin
                shv = shv | (int'(txd) << bi);
                bi++;
            end else begin
                chk("R3 stop bit", int'(txd), 1);
                if (rd_p < wr_p) begin
                    chk("R3 data", shv, exp_data[rd_p % 4096]);
                    rd_p++;
                end
                in_frame = 0;
            end
        end
    end

    task automatic settle_check(input string tag);
        repeat (100) @(negedge clk);
        while (m_busy) m_complete();
        chk({tag, " rts"}, int'(rts), int'(m_rts));
        chk({tag, " brk"}, int'(brk), int'(m_brk));
        chk({tag, " buf_empty"}, int'(buf_empty), int'(m_be));
        chk({tag, " shift_empty"}, int'(shift_empty), 1);
        chk("R10 line level", int'(txd), m_brk ? 0 : 1);
        chk("R3 frames out", rd_p, wr_p);
    endtask

    task automatic op_write(input int d);
        @(negedge clk); buf_wr = 1; buf_data = d[7:0];
        @(negedge clk); buf_wr = 0;
        m_write(d & 8'hff);
    endtask

    task automatic op_rtson(input bit v);
        @(negedge clk); rtson_wr = 1; rtson_val = v;
        @(negedge clk); rtson_wr = 0;
        if (v) chk("R5 rts next edge", int'(rts), 1);
        m_rtson(v);
    endtask

    task automatic op_brkon(input bit v);
        @(negedge clk); brkon_wr = 1; brkon_val = v;
        @(negedge clk); brkon_wr = 0;
        m_brkon(v);
    endtask

    task automatic op_cts(input bit v);
        @(negedge clk); cts = v;
        @(negedge clk);
        m_setcts(v);
    endtask

    task automatic op_len(input int v);
        @(negedge clk); len_code = v[1:0]; m_len = v;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1a2b3c4d));
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rts", int'(rts), 0);
        chk("R1 brk", int'(brk), 0);
        chk("R1 buf_empty", int'(buf_empty), 1);
        chk("R1 shift_empty", int'(shift_empty), 1);
        chk("R1 txd", int'(txd), 1);

        // R2 write with rts low: held
        op_write(8'hA5);
        chk("R2 no start while rts low", int'(shift_empty), 1);
        settle_check("R2");
        // R5 raise rts with cts active: pending starts
        op_cts(1);
        op_rtson(1);
        settle_check("R5 R4");
        // burst then cts drop: second held
        op_len(0);
        op_write(8'h3C);
        op_write(8'hF1);
        op_cts(0);
        settle_check("R4 held");
        op_rtson(0);
        settle_check("R6 rts kept");
        op_cts(1);
        settle_check("R9 R4");
        // break sequence
        op_len(2);
        op_rtson(1);
        op_brkon(1);
        settle_check("R7");
        op_write(8'h5A);
        settle_check("R7 held in break");
        op_brkon(0);
        settle_check("R8 release sends");
        op_brkon(1);
        op_rtson(0);
        settle_check("R6 break blocks drop");
        op_brkon(0);
        settle_check("R8 rts drop");

        for (int i = 0; i < 300; i++) begin
            int k = $urandom_range(0, 6);
            case (k)
                0: begin op_write($urandom_range(0, 255)); settle_check("R2"); end
                1: begin op_rtson($urandom_range(0, 1)); settle_check("R5 R6"); end
                2: begin op_brkon($urandom_range(0, 1)); settle_check("R7 R8"); end
                3: begin op_cts($urandom_range(0, 1)); settle_check("R9"); end
                4: op_len($urandom_range(0, 3));
                5: begin
                    op_write($urandom_range(0, 255));
                    op_write($urandom_range(0, 255));
                    if ($urandom_range(0, 1) == 1) op_cts(0);
                    settle_check("R4 burst");
                end
                default: begin
                    op_write($urandom_range(0, 255));
                    op_rtson(0);
                    settle_check("R6 R4");
                end
            endcase
        end
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule